// File: doc/BRIEF.md
# Converter Lane Link-Start Transmitter

This block is the link-layer front end of one transmit lane of a serial data converter. Each cycle it emits one word of `LANE_BYTES` octets and one control flag per octet. An external 8b/10b encoder consumes both. The receiver asks for link (re)establishment by pulling an active-low request line low. The block answers by filling the lane with comma characters for as long as the request is held. When the request is released, it plays out a fixed lane alignment pattern and then passes sampled payload through.

The request line is brought in through a flop synchronizer. Time is organised in frames of `FRAME_WORDS` words and multiframes of `MF_FRAMES` frames. A change of phase always takes effect on the first word of a frame. Alignment always starts and ends on a multiframe edge. A low level that lasts fewer than `ERR_FRAMES` frames is taken as an error report from the receiver and does not restart the link. A bring-up test code on `test_mode` makes the block cycle forever between one multiframe of commas and the full alignment pattern, whatever the request line does.

Top module: `link_sync_responder`

## Requirements
- R1: While `rst` is high, and on the first word after it, `data_out` and `k_out` are all zero. The block starts in the payload phase.
- R2: `sync_req_n` passes through a two-flop synchronizer. The comma phase begins only on the first word of a frame, and only once the synchronized request has been low for at least `ERR_FRAMES`×`FRAME_WORDS` consecutive words. A shorter low pulse changes no output.
- R3: In the comma phase every octet is 0xBC and every bit of `k_out` is 1.
- R4: The comma phase continues until the synchronized request is high at the last word of a multiframe. The alignment pattern then starts on the next word, which is word 0 of a multiframe. It lasts exactly `ILA_MF` multiframes and is followed directly by payload.
- R5: Octets are numbered within a multiframe as word position × `LANE_BYTES` + lane, where lane 0 is `data_out[7:0]`. In every alignment multiframe, octet 0 is 0x1C and the last octet is 0x7C, both with their K bit set.
- R6: In the second alignment multiframe (index 1), octet 1 is 0x9C with K set. Octets 2 to 1+`CFG_BYTES` carry configuration values `CFG_BASE`+n (n = 0 upward), with K clear.
- R7: Every other alignment octet equals its own octet number, with K clear.
- R8: In the payload phase, `data_out` is `data_in` delayed by one clock, lane for lane, and `k_out` is zero.
- R9: While the request line stays high and the test code is not selected, no comma or alignment octet is ever sent.
- R10: With `test_mode` = 3'b011, the block enters commas at the next frame start. It then alternates forever between one multiframe of commas and one full alignment pattern, ignoring `sync_req_n`.
- R11: A qualifying low request (as in R2) during the alignment pattern abandons it and re-enters the comma phase at the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane word clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_req_n | input | 1 | Active-low link request from the receiver, asynchronous |
| test_mode | input | 3 | Link test selection; 3'b011 loops commas and alignment |
| data_in | input | 8×LANE_BYTES | Sampled payload word, lane 0 in bits 7:0 |
| data_out | output | 8×LANE_BYTES | Octets to the encoder |
| k_out | output | LANE_BYTES | Per-octet control flag |

## Verification
The bench sweeps request-low widths from one word to four frames and beyond. Every width is started at every word position of a multiframe, so both the error-pulse threshold and frame-start alignment are hit on every side. A design that counted frames instead of words, or that left out a synchronizer stage, would either start commas one frame early or late, or let a three-frame glitch drop the link. A design that started alignment mid-multiframe would misplace the 0x1C/0x7C markers and the configuration octets. Re-requests during alignment and the test loop with a toggling request line catch a block that finishes the pattern anyway, or that lets the request line leak into test mode.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [1:0] {
    PH_DATA = 2'd0,
    PH_CGS  = 2'd1,
    PH_ILA  = 2'd2
  } phase_t;

  localparam logic [7:0] SYM_COMMA = 8'hBC;
  localparam logic [7:0] SYM_MF_START = 8'h1C;
  localparam logic [7:0] SYM_MF_END = 8'h7C;
  localparam logic [7:0] SYM_CFG_MARK = 8'h9C;
  localparam logic [2:0] TM_ALIGN_LOOP = 3'b011;
endpackage

// File: rtl/srt_sync.sv
module srt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/srt_ctrl.sv
module srt_ctrl
  import srt_pkg::*;
#(
  parameter int FRAME_WORDS = 2,
  parameter int MF_FRAMES   = 4,
  parameter int ILA_MF      = 4,
  parameter int ERR_FRAMES  = 4,
  parameter int WPOS_W      = 3,
  parameter int MF_W        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_ok,
  input  logic              test_loop,
  output phase_t            phase,
  output logic [WPOS_W-1:0] wpos,
  output logic [MF_W-1:0]   mf_idx
);
  localparam int MFW   = FRAME_WORDS * MF_FRAMES;
  localparam int THR   = ERR_FRAMES * FRAME_WORDS;
  localparam int LW    = $clog2(THR + 1);
  localparam int FPW   = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam logic [WPOS_W-1:0] W_LAST = WPOS_W'(MFW - 1);
  localparam logic [FPW-1:0]    F_LAST = FPW'(FRAME_WORDS - 1);
  localparam logic [LW-1:0]     THR_V  = LW'(THR);
  localparam logic [MF_W-1:0]   MF_LAST = MF_W'(ILA_MF - 1);

  phase_t            ph_q, ph_d;
  logic [WPOS_W-1:0] wpos_q;
  logic [FPW-1:0]    fpos_q;
  logic [LW-1:0]     low_q, run_d;
  logic [MF_W-1:0]   mf_q, mf_d;
  logic              frame_end, mf_end, resync;

  assign frame_end = (fpos_q == F_LAST);
  assign mf_end    = (wpos_q == W_LAST);

  always_comb begin
    if (sync_ok)           run_d = '0;
    else if (low_q == THR_V) run_d = low_q;
    else                   run_d = low_q + 1'b1;
  end

  assign resync = !test_loop && (run_d >= THR_V);

  always_comb begin
    ph_d = ph_q;
    mf_d = mf_q;
    unique case (ph_q)
      PH_DATA: begin
        if (frame_end && (test_loop || resync)) ph_d = PH_CGS;
      end
      PH_CGS: begin
        if (mf_end && (test_loop || sync_ok)) begin
          ph_d = PH_ILA;
          mf_d = '0;
        end
      end
      PH_ILA: begin
        if (frame_end && resync) begin
          ph_d = PH_CGS;
        end else if (mf_end) begin
          if (mf_q == MF_LAST) ph_d = test_loop ? PH_CGS : PH_DATA;
          else                 mf_d = mf_q + 1'b1;
        end
      end
      default: ph_d = PH_DATA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_DATA;
      wpos_q <= '0;
      fpos_q <= '0;
      low_q  <= '0;
      mf_q   <= '0;
    end else begin
      ph_q   <= ph_d;
      mf_q   <= mf_d;
      low_q  <= run_d;
      wpos_q <= mf_end ? '0 : wpos_q + 1'b1;
      fpos_q <= frame_end ? '0 : fpos_q + 1'b1;
    end
  end

  assign phase  = ph_q;
  assign wpos   = wpos_q;
  assign mf_idx = mf_q;

  // R2
  cgs_entry_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_CGS && $past(ph_q) != PH_CGS && !$past(test_loop))
      |-> (!$past(sync_ok) && $past(low_q) >= LW'(THR - 1)));

  // R2
  phase_on_frame_start_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q != $past(ph_q)) |-> (fpos_q == '0));

  // R4
  ila_start_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_ILA && $past(ph_q) == PH_CGS) |-> (wpos_q == '0 && mf_q == '0));

  // R4
  ila_full_length_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_DATA && $past(ph_q) == PH_ILA)
      |-> (wpos_q == '0 && $past(mf_q) == MF_LAST));
endmodule

// File: rtl/srt_octet_gen.sv
module srt_octet_gen
  import srt_pkg::*;
#(
  parameter int          LANE_BYTES = 4,
  parameter int          MFW        = 8,
  parameter int          CFG_BYTES  = 14,
  parameter logic [7:0]  CFG_BASE   = 8'h40,
  parameter int          WPOS_W     = 3,
  parameter int          MF_W       = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  phase_t                  phase,
  input  logic [WPOS_W-1:0]       wpos,
  input  logic [MF_W-1:0]         mf_idx,
  input  logic [8*LANE_BYTES-1:0] data_in,
  output logic [8*LANE_BYTES-1:0] data_out,
  output logic [LANE_BYTES-1:0]   k_out
);
  localparam int MF_OCTETS = MFW * LANE_BYTES;

  logic [8*LANE_BYTES-1:0] oct_d;
  logic [LANE_BYTES-1:0]   kf_d;
  logic [8*LANE_BYTES-1:0] oct_q;
  logic [LANE_BYTES-1:0]   kf_q;

  for (genvar j = 0; j < LANE_BYTES; j++) begin : g_lane
    logic [7:0] oct;
    logic       kf;
    int         pos;

    always_comb begin
      pos = int'(wpos) * LANE_BYTES + j;
      oct = data_in[8*j +: 8];
      kf  = 1'b0;
      unique case (phase)
        PH_CGS: begin
          oct = SYM_COMMA;
          kf  = 1'b1;
        end
        PH_ILA: begin
          if (pos == 0) begin
            oct = SYM_MF_START;
            kf  = 1'b1;
          end else if (pos == MF_OCTETS - 1) begin
            oct = SYM_MF_END;
            kf  = 1'b1;
          end else if (mf_idx == MF_W'(1) && pos == 1) begin
            oct = SYM_CFG_MARK;
            kf  = 1'b1;
          end else if (mf_idx == MF_W'(1) && pos >= 2 && pos < 2 + CFG_BYTES) begin
            oct = CFG_BASE + 8'(pos - 2);
          end else begin
            oct = 8'(pos);
          end
        end
        default: ;
      endcase
    end

    assign oct_d[8*j +: 8] = oct;
    assign kf_d[j]         = kf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oct_q <= '0;
      kf_q  <= '0;
    end else begin
      oct_q <= oct_d;
      kf_q  <= kf_d;
    end
  end

  assign data_out = oct_q;
  assign k_out    = kf_q;

  // R3
  comma_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CGS) |=> (k_out == '1 && data_out == {LANE_BYTES{SYM_COMMA}}));

  // R8
  payload_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA) |=> (k_out == '0 && data_out == $past(data_in)));

  // R5
  mf_start_marker_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ILA && wpos == '0) |=> (k_out[0] && data_out[7:0] == SYM_MF_START));
endmodule

// File: rtl/link_sync_responder.sv
module link_sync_responder
  import srt_pkg::*;
#(
  parameter int         LANE_BYTES  = 4,
  parameter int         FRAME_WORDS = 2,
  parameter int         MF_FRAMES   = 4,
  parameter int         ILA_MF      = 4,
  parameter int         ERR_FRAMES  = 4,
  parameter int         SYNC_STAGES = 2,
  parameter int         CFG_BYTES   = 14,
  parameter logic [7:0] CFG_BASE    = 8'h40
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sync_req_n,
  input  logic [2:0]              test_mode,
  input  logic [8*LANE_BYTES-1:0] data_in,
  output logic [8*LANE_BYTES-1:0] data_out,
  output logic [LANE_BYTES-1:0]   k_out
);
  localparam int MFW    = FRAME_WORDS * MF_FRAMES;
  localparam int WPOS_W = (MFW > 1) ? $clog2(MFW) : 1;
  localparam int MF_W   = (ILA_MF > 1) ? $clog2(ILA_MF) : 1;

  logic              sync_ok;
  logic              test_loop;
  phase_t            phase;
  logic [WPOS_W-1:0] wpos;
  logic [MF_W-1:0]   mf_idx;

  assign test_loop = (test_mode == TM_ALIGN_LOOP);

  srt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sync_req_n),
    .q   (sync_ok)
  );

  srt_ctrl #(
    .FRAME_WORDS (FRAME_WORDS),
    .MF_FRAMES   (MF_FRAMES),
    .ILA_MF      (ILA_MF),
    .ERR_FRAMES  (ERR_FRAMES),
    .WPOS_W      (WPOS_W),
    .MF_W        (MF_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sync_ok   (sync_ok),
    .test_loop (test_loop),
    .phase     (phase),
    .wpos      (wpos),
    .mf_idx    (mf_idx)
  );

  srt_octet_gen #(
    .LANE_BYTES (LANE_BYTES),
    .MFW        (MFW),
    .CFG_BYTES  (CFG_BYTES),
    .CFG_BASE   (CFG_BASE),
    .WPOS_W     (WPOS_W),
    .MF_W       (MF_W)
  ) u_gen (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .wpos     (wpos),
    .mf_idx   (mf_idx),
    .data_in  (data_in),
    .data_out (data_out),
    .k_out    (k_out)
  );
endmodule

// File: tb/link_sync_responder_tb.sv
module link_sync_responder_tb;
  localparam int LB = 4, FW = 2, MFF = 4, ILAN = 4, ERRF = 4, CFGN = 14;
  localparam logic [7:0] CFGB = 8'h40;
  localparam int MFW = FW * MFF;
  localparam int THR = ERRF * FW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_n = 1'b1;
  logic [2:0] tmode = 3'b000;
  logic [8*LB-1:0] din = '0;
  logic [8*LB-1:0] dout;
  logic [LB-1:0] kout;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit chk_en = 0, done = 0;
  string scen = "R1 reset";

  // bench-side model state
  int m_st = 0, m_w = 0, m_mf = 0, m_low = 0;
  logic m_s1 = 1'b1, m_s2 = 1'b1;
  logic [8*LB-1:0] e_d = '0;
  logic [LB-1:0] e_k = '0;
  string e_tag = "R1";

  always #10 clk = ~clk;

  link_sync_responder #(
    .LANE_BYTES(LB), .FRAME_WORDS(FW), .MF_FRAMES(MFF), .ILA_MF(ILAN),
    .ERR_FRAMES(ERRF), .SYNC_STAGES(2), .CFG_BYTES(CFGN), .CFG_BASE(CFGB)
  ) u_dut (
    .clk(clk), .rst(rst), .sync_req_n(sync_n), .test_mode(tmode),
    .data_in(din), .data_out(dout), .k_out(kout)
  );

  function automatic void expect_word(input int st, input int w, input int mf,
                                      input logic [8*LB-1:0] d,
                                      output logic [8*LB-1:0] od,
                                      output logic [LB-1:0] ok);
    for (int j = 0; j < LB; j++) begin
      int p;
      p = w * LB + j;
      if (st == 0) begin
        od[8*j +: 8] = d[8*j +: 8]; ok[j] = 1'b0;
      end else if (st == 1) begin
        od[8*j +: 8] = 8'hBC; ok[j] = 1'b1;
      end else if (p == 0) begin
        od[8*j +: 8] = 8'h1C; ok[j] = 1'b1;
      end else if (p == MFW * LB - 1) begin
        od[8*j +: 8] = 8'h7C; ok[j] = 1'b1;
      end else if (mf == 1 && p == 1) begin
        od[8*j +: 8] = 8'h9C; ok[j] = 1'b1;
      end else if (mf == 1 && p >= 2 && p < 2 + CFGN) begin
        od[8*j +: 8] = CFGB + 8'(p - 2); ok[j] = 1'b0;
      end else begin
        od[8*j +: 8] = 8'(p); ok[j] = 1'b0;
      end
    end
  endfunction

  always @(posedge clk) begin
    logic [8*LB-1:0] td;
    logic [LB-1:0] tk;
    int run;
    bit tl, fe, me, req;
    if (rst) begin
      m_st <= 0; m_w <= 0; m_mf <= 0; m_low <= 0;
      m_s1 <= 1'b1; m_s2 <= 1'b1;
      e_d <= '0; e_k <= '0; e_tag <= "R1";
    end else begin
      expect_word(m_st, m_w, m_mf, din, td, tk);
      e_d <= td; e_k <= tk;
      e_tag <= (m_st == 0) ? "R8 payload" : (m_st == 1) ? "R3 comma" : "R5/R6/R7 alignment";
      tl  = (tmode == 3'b011);
      run = m_s2 ? 0 : ((m_low + 1 > THR) ? THR : m_low + 1);
      fe  = ((m_w % FW) == FW - 1);
      me  = (m_w == MFW - 1);
      req = !tl && (run >= THR);
      case (m_st)
        0: if (fe && (tl || req)) m_st <= 1;
        1: if (me && (tl || m_s2)) begin m_st <= 2; m_mf <= 0; end
        default: begin
          if (fe && req) m_st <= 1;
          else if (me) begin
            if (m_mf == ILAN - 1) m_st <= tl ? 1 : 0;
            else m_mf <= m_mf + 1;
          end
        end
      endcase
      m_low <= run;
      m_w   <= (m_w + 1) % MFW;
      m_s2  <= m_s1;
      m_s1  <= sync_n;
    end
  end

  always @(negedge clk) begin
    if (chk_en && !done) begin
      n_cmp++;
      if (dout !== e_d || kout !== e_k) begin
        n_bad++;
        $display("FAIL %s [%s] cyc %0d: got d=%h k=%b, expected d=%h k=%b",
                 e_tag, scen, cyc, dout, kout, e_d, e_k);
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      din = 32'h9E37_79B9 * cyc + 32'h0102_0304;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pos(input int p);
    @(negedge clk);
    while (m_w != p) @(negedge clk);
  endtask

  initial begin
    idle(4);
    // R1: outputs zero while held in reset
    n_cmp++;
    if (dout !== '0 || kout !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: got d=%h k=%b, expected d=0 k=0", dout, kout);
    end
    rst = 1'b0;
    chk_en = 1;

    scen = "R9 request idle high";
    idle(60);

    scen = "R2/R4 low-width sweep";
    for (int d = 1; d <= 16; d++) begin
      for (int ph = 0; ph < MFW; ph++) begin
        wait_pos(ph);
        sync_n = 1'b0;
        idle(d);
        sync_n = 1'b1;
        idle(50);
      end
    end

    scen = "R3 long comma hold";
    sync_n = 1'b0;
    idle(45);
    sync_n = 1'b1;
    idle(50);

    scen = "R11 re-request during alignment";
    sync_n = 1'b0;
    idle(20);
    sync_n = 1'b1;
    idle(14);
    sync_n = 1'b0;
    idle(11);
    sync_n = 1'b1;
    idle(55);
    sync_n = 1'b0;
    idle(20);
    sync_n = 1'b1;
    idle(16);
    sync_n = 1'b0;
    idle(5);
    sync_n = 1'b1;
    idle(55);

    scen = "R10 test loop ignores request";
    tmode = 3'b011;
    for (int i = 0; i < 160; i++) begin
      sync_n = ((i / 3) % 2 == 0);
      @(negedge clk);
    end
    sync_n = 1'b0;
    idle(40);
    sync_n = 1'b1;
    idle(20);
    tmode = 3'b000;
    idle(90);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule